// File: doc/BRIEF.md
# Register write-protection lock unit

This unit sits between a bus master and the register bank of a peripheral and adds byte-granular write locking. Every request is one 32-bit word access with byte strobes and a privilege flag. Address bits [7:5] select a region and bits [4:2] select a word inside it. Allowed accesses to the peripheral's registers are forwarded on a downstream port, which completes in the same cycle. Blocked accesses never reach the peripheral and return a transfer error.

Each register byte has a soft lock. A lock can be set in two ways: directly through a per-register lock word, or as a side effect of writing the register through its mirror alias. A write that touches any locked byte is refused whole. A sticky hard-lock bit freezes every lock until reset. A user-mode permission bit decides whether user-privilege writes are accepted. A synthesis-time mask names the bytes that can be protected at all. Locks on the other bytes are tied to zero.

Top module: `reg_lock_unit`

## Requirements
- R1: After reset every soft lock, the hard-lock bit and the user-permission bit are 0. Each request with `req_valid` high gets exactly one response (`rsp_valid` high) on the next clock cycle, and there is no response in any other cycle.
- R2: Address bits [7:5] encode the region: 0 = register space, 1 = reserved, 2 = mirror, 3 = lock words, 4 = configuration, 5 to 7 = reserved. A register-space access to word k (k below NUM_REGS) is forwarded with `dn_idx` = k and the request's strobes and data. A read returns `dn_rdata` in the response.
- R3: A mirror write that is accepted updates the register and sets the soft lock of each strobed byte whose bit is 1 in PROT_MASK (bit 4k+i is byte i of word k). Locks of bytes whose mask bit is 0 always read 0.
- R4: A mirror read returns the register data and leaves every lock unchanged.
- R5: A register-space or mirror write whose strobes include any byte with its lock set is not forwarded at all, including its unlocked bytes, and it returns an error.
- R6: Lock word k (region 3) reads back the locks of register k in bits [3:0], where bit i is byte i. Writing it loads bits [3:0] of the write data: 1 sets a lock and 0 clears it, and the mask still applies.
- R7: Configuration word 0 holds the hard lock in bit 0 and user permission in bit 1. Once the hard lock is set it stays 1 until reset. From then on, every write to a lock word or to the mirror returns an error and changes nothing.
- R8: Each of the following returns an error and read data 0, and has no effect: any reserved-region access, a register, mirror or lock word index of NUM_REGS or more, a configuration index other than 0, or address bits [1:0] not equal to 0.
- R9: While user permission is 0, every write with `req_user` = 1 is blocked with an error in every region. With user permission set to 1, such writes are treated like supervisor writes.
- R10: An error that the peripheral reports on `dn_err` for a forwarded access reaches `rsp_err`. A mirror write that the peripheral rejects sets no locks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_user | input | 1 | 1 = user privilege, 0 = supervisor |
| req_addr | input | AW | Byte address (region in [AW-1:AW-3]) |
| req_wdata | input | 32 | Write data |
| req_strb | input | 4 | Byte strobes |
| rsp_valid | output | 1 | Response, one cycle after the request |
| rsp_err | output | 1 | Transfer error |
| rsp_rdata | output | 32 | Read data (0 on error) |
| dn_valid | output | 1 | Forwarded access to the peripheral |
| dn_write | output | 1 | Forwarded write flag |
| dn_idx | output | IDX_W | Register word index |
| dn_wdata | output | 32 | Forwarded write data |
| dn_strb | output | 4 | Forwarded byte strobes |
| dn_rdata | input | 32 | Peripheral read data, same cycle |
| dn_err | input | 1 | Peripheral error, same cycle |

## Verification
A wrong lock bit is only visible when a write attempts to hit it. It then shows on the next response as a spurious or missing error, and on the following read-back as a register value that changed or failed to change. This is why the bench sweeps every lock pattern against every strobe pattern. A hard lock that clears, or locks that drift while frozen, show up at the first lock-word or configuration read after the event, one cycle after that read is issued. A decode fault shows on the response of the very access that hits the wrong region.

// File: rtl/rlu_pkg.sv
package rlu_pkg;

  typedef enum logic [2:0] {
    RG_DIRECT = 3'd0,
    RG_MIRROR = 3'd1,
    RG_LOCK   = 3'd2,
    RG_CFG    = 3'd3,
    RG_BAD    = 3'd4
  } region_e;

  // map the three-bit region field of the address to a region class
  function automatic region_e region_of(input logic [2:0] field);
    case (field)
      3'd0:    return RG_DIRECT;
      3'd2:    return RG_MIRROR;
      3'd3:    return RG_LOCK;
      3'd4:    return RG_CFG;
      default: return RG_BAD;
    endcase
  endfunction

  // bytes of a write that collide with an existing lock
  function automatic logic [3:0] lock_hits(input logic [3:0] locks,
                                           input logic [3:0] strb);
    return locks & strb;
  endfunction

  // lock bits after an accepted mirror write
  function automatic logic [3:0] mirror_lock_next(input logic [3:0] cur,
                                                  input logic [3:0] strb,
                                                  input logic [3:0] prot);
    return cur | (strb & prot);
  endfunction

endpackage

// File: rtl/rlu_decode.sv
module rlu_decode
  import rlu_pkg::*;
#(
  parameter int AW       = 8,
  parameter int NUM_REGS = 4,
  localparam int OFF_W   = AW - 5,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic [AW-1:0]    addr,
  output region_e          region,
  output logic [IDX_W-1:0] idx,
  output logic             off_ok
);

  logic [OFF_W-1:0] off;
  logic             aligned;

  assign off     = addr[AW-4:2];
  assign aligned = (addr[1:0] == 2'b00);
  assign region  = region_of(addr[AW-1:AW-3]);
  assign idx     = off[IDX_W-1:0];

  always_comb begin
    case (region)
      RG_DIRECT, RG_MIRROR, RG_LOCK: off_ok = aligned && (32'(off) < NUM_REGS);
      RG_CFG:                        off_ok = aligned && (off == '0);
      default:                       off_ok = 1'b0;
    endcase
  end

endmodule

// File: rtl/rlu_access_ctrl.sv
module rlu_access_ctrl
  import rlu_pkg::*;
(
  input  logic       req_valid,
  input  logic       req_write,
  input  logic       req_user,
  input  logic [3:0] req_strb,
  input  region_e    region,
  input  logic       off_ok,
  input  logic       hard_lock,
  input  logic       user_ok,
  input  logic [3:0] cur_locks,
  input  logic       dn_err,
  output logic       dn_valid,
  output logic       ms_en,
  output logic       lk_wr_en,
  output logic       cfg_wr_en,
  output logic       err,
  output logic       ev_user_block,
  output logic       ev_lock_block,
  output logic       ev_hl_block,
  output logic       ev_decode_err
);

  logic wr, live, reg_space, hits;

  assign wr            = req_valid && req_write;
  assign ev_user_block = wr && req_user && !user_ok;
  assign ev_decode_err = req_valid && !off_ok && !ev_user_block;
  assign live          = req_valid && off_ok && !ev_user_block;
  assign reg_space     = (region == RG_DIRECT) || (region == RG_MIRROR);
  assign hits          = |lock_hits(cur_locks, req_strb);

  assign ev_hl_block   = live && req_write && hard_lock &&
                         ((region == RG_MIRROR) || (region == RG_LOCK));
  assign ev_lock_block = live && req_write && reg_space && hits && !ev_hl_block;

  assign dn_valid  = live && reg_space && !ev_hl_block && !ev_lock_block;
  assign ms_en     = dn_valid && req_write && (region == RG_MIRROR) && !dn_err;
  assign lk_wr_en  = live && req_write && (region == RG_LOCK) && !ev_hl_block;
  assign cfg_wr_en = live && req_write && (region == RG_CFG);

  assign err = ev_user_block || ev_decode_err || ev_hl_block || ev_lock_block ||
               (dn_valid && dn_err);

endmodule

// File: rtl/rlu_lock_store.sv
module rlu_lock_store #(
  parameter int NUM_REGS = 4,
  parameter logic [NUM_REGS*4-1:0] PROT_MASK = '1,
  localparam int NB    = NUM_REGS * 4,
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_wr_en,
  input  logic [3:0]       lk_wr_bits,
  input  logic             ms_en,
  input  logic [3:0]       ms_strb,
  input  logic [IDX_W-1:0] idx,
  input  logic             cfg_wr_en,
  input  logic [1:0]       cfg_bits,
  output logic [NB-1:0]    locks,
  output logic             hard_lock,
  output logic             user_ok
);

  for (genvar b = 0; b < NB; b++) begin : g_byte
    localparam int REG  = b / 4;
    localparam int LANE = b % 4;
    if (PROT_MASK[b]) begin : g_prot
      logic q;
      always_ff @(posedge clk) begin
        if (!rst_n)                                          q <= 1'b0;
        else if (lk_wr_en && idx == IDX_W'(REG))             q <= lk_wr_bits[LANE];
        else if (ms_en && idx == IDX_W'(REG) && ms_strb[LANE]) q <= 1'b1;
      end
      assign locks[b] = q;
    end else begin : g_fixed
      assign locks[b] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hard_lock <= 1'b0;
      user_ok   <= 1'b0;
    end else if (cfg_wr_en) begin
      hard_lock <= hard_lock | cfg_bits[0];
      user_ok   <= cfg_bits[1];
    end
  end

endmodule

// File: rtl/reg_lock_unit.sv
module reg_lock_unit
  import rlu_pkg::*;
#(
  parameter int AW       = 8,
  parameter int NUM_REGS = 4,
  parameter logic [NUM_REGS*4-1:0] PROT_MASK = {{(NUM_REGS*4-2){1'b1}}, 2'b00},
  localparam int NB    = NUM_REGS * 4,
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             req_user,
  input  logic [AW-1:0]    req_addr,
  input  logic [31:0]      req_wdata,
  input  logic [3:0]       req_strb,
  output logic             rsp_valid,
  output logic             rsp_err,
  output logic [31:0]      rsp_rdata,
  output logic             dn_valid,
  output logic             dn_write,
  output logic [IDX_W-1:0] dn_idx,
  output logic [31:0]      dn_wdata,
  output logic [3:0]       dn_strb,
  input  logic [31:0]      dn_rdata,
  input  logic             dn_err
);

  region_e          region;
  logic [IDX_W-1:0] idx;
  logic             off_ok;
  logic [NB-1:0]    locks;
  logic             hard_lock, user_ok;
  logic [3:0]       cur_locks;
  logic             ms_en, lk_wr_en, cfg_wr_en, err;
  logic             ev_user_block, ev_lock_block, ev_hl_block, ev_decode_err;
  logic [31:0]      rdata_nxt;

  rlu_decode #(.AW(AW), .NUM_REGS(NUM_REGS)) u_decode (
    .addr(req_addr), .region(region), .idx(idx), .off_ok(off_ok)
  );

  always_comb begin
    cur_locks = '0;
    for (int r = 0; r < NUM_REGS; r++)
      if (idx == IDX_W'(r)) cur_locks = locks[r*4 +: 4];
  end

  rlu_access_ctrl u_ctrl (
    .req_valid(req_valid), .req_write(req_write), .req_user(req_user),
    .req_strb(req_strb), .region(region), .off_ok(off_ok),
    .hard_lock(hard_lock), .user_ok(user_ok), .cur_locks(cur_locks),
    .dn_err(dn_err), .dn_valid(dn_valid), .ms_en(ms_en), .lk_wr_en(lk_wr_en),
    .cfg_wr_en(cfg_wr_en), .err(err), .ev_user_block(ev_user_block),
    .ev_lock_block(ev_lock_block), .ev_hl_block(ev_hl_block),
    .ev_decode_err(ev_decode_err)
  );

  rlu_lock_store #(.NUM_REGS(NUM_REGS), .PROT_MASK(PROT_MASK)) u_store (
    .clk(clk), .rst_n(rst_n), .lk_wr_en(lk_wr_en), .lk_wr_bits(req_wdata[3:0]),
    .ms_en(ms_en), .ms_strb(req_strb), .idx(idx), .cfg_wr_en(cfg_wr_en),
    .cfg_bits(req_wdata[1:0]), .locks(locks), .hard_lock(hard_lock),
    .user_ok(user_ok)
  );

  assign dn_write = req_write;
  assign dn_idx   = idx;
  assign dn_wdata = req_wdata;
  assign dn_strb  = req_strb;

  always_comb begin
    rdata_nxt = '0;
    if (!err && !req_write) begin
      case (region)
        RG_DIRECT, RG_MIRROR: rdata_nxt = dn_rdata;
        RG_LOCK:              rdata_nxt = {28'd0, cur_locks};
        RG_CFG:               rdata_nxt = {30'd0, user_ok, hard_lock};
        default:              rdata_nxt = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && err;
      rsp_rdata <= req_valid ? rdata_nxt : '0;
    end
  end

  // R1: one response per request, next cycle
  a_r1_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r1_no_stray_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R3: bytes outside the mask never hold a lock
  a_r3_unprot_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (locks & ~PROT_MASK) == '0);
  // R4: reads never move a lock
  a_r4_read_keeps_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> $stable(locks));
  // R5: a colliding write is not forwarded and errors
  a_r5_block_no_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    ev_lock_block |-> !dn_valid);
  a_r5_block_errs: assert property (@(posedge clk) disable iff (!rst_n)
    ev_lock_block |=> rsp_err);
  // R7: hard lock sticky and freezes locks
  a_r7_hl_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    hard_lock |=> hard_lock);
  a_r7_locks_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    hard_lock |=> $stable(locks));
  // R8: decode errors never reach the peripheral
  a_r8_decode_no_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    ev_decode_err |-> !dn_valid);
  // R9: blocked user writes error and do not forward
  a_r9_user_block: assert property (@(posedge clk) disable iff (!rst_n)
    ev_user_block |-> (!dn_valid ##1 rsp_err));
  // R10: peripheral errors pass through
  a_r10_dn_err_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && dn_err) |=> rsp_err);

endmodule

// File: tb/reg_lock_unit_bench.sv
module reg_lock_unit_bench;

  localparam logic [15:0] PM = 16'hFFFC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_strb = '0;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic        dn_valid, dn_write;
  logic [1:0]  dn_idx;
  logic [31:0] dn_wdata;
  logic [3:0]  dn_strb;
  logic [31:0] dn_rdata;
  logic        dn_err;

  logic [31:0] parr [4];
  logic [31:0] exp_reg [4];
  logic        inj_en = 1'b0;
  logic [1:0]  inj_idx = '0;
  int          checks = 0, errors = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  reg_lock_unit u_reg_lock_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_user(req_user), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_strb(req_strb), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .dn_valid(dn_valid), .dn_write(dn_write),
    .dn_idx(dn_idx), .dn_wdata(dn_wdata), .dn_strb(dn_strb),
    .dn_rdata(dn_rdata), .dn_err(dn_err)
  );

  // peripheral model: plain register array, rejects writes when it errors
  assign dn_rdata = parr[dn_idx];
  assign dn_err   = inj_en && (dn_idx == inj_idx);
  always_ff @(posedge clk) begin
    if (dn_valid && dn_write && !dn_err)
      for (int i = 0; i < 4; i++)
        if (dn_strb[i]) parr[dn_idx][i*8 +: 8] <= dn_wdata[i*8 +: 8];
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input bit w, input logic [2:0] rg, input logic [2:0] off,
                     input logic [31:0] d, input logic [3:0] s, input bit u,
                     output bit e, output logic [31:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_user = u;
    req_addr = {rg, off, 2'b00}; req_wdata = d; req_strb = s;
    @(negedge clk);
    req_valid = 1'b0;
    e = rsp_err; rd = rsp_rdata;
    chk(rsp_valid === 1'b1, "R1 response one cycle later", {31'd0, rsp_valid}, 1);
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d,
                                        input logic [3:0] s);
    logic [31:0] r = old;
    for (int i = 0; i < 4; i++) if (s[i]) r[i*8 +: 8] = d[i*8 +: 8];
    return r;
  endfunction

  task automatic read_all(input string tag);
    bit e; logic [31:0] rd;
    for (int k = 0; k < 4; k++) begin
      acc(0, 3'd0, 3'(k), 0, 4'hF, 0, e, rd);
      chk(!e && rd == exp_reg[k], tag, rd, exp_reg[k]);
    end
  endtask

  initial begin
    bit e; logic [31:0] rd; logic [31:0] d; bit exp_e;
    for (int k = 0; k < 4; k++) begin parr[k] = 32'h0; exp_reg[k] = 32'h0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R1 idle after reset", {31'd0, rsp_valid}, 0);

    // R1: reset values readable
    acc(0, 3'd4, 3'd0, 0, 4'hF, 0, e, rd);
    chk(!e && rd == 0, "R1 config reset", rd, 0);
    for (int k = 0; k < 4; k++) begin
      acc(0, 3'd3, 3'(k), 0, 4'hF, 0, e, rd);
      chk(!e && rd == 0, "R1 locks reset", rd, 0);
    end

    // R9: user write blocked while permission is 0
    acc(1, 3'd0, 3'd1, 32'hDEADBEEF, 4'hF, 1, e, rd);
    chk(e, "R9 user write error", {31'd0, e}, 1);
    acc(1, 3'd3, 3'd1, 32'hF, 4'hF, 1, e, rd);
    chk(e, "R9 user lock write error", {31'd0, e}, 1);
    acc(0, 3'd3, 3'd1, 0, 4'hF, 0, e, rd);
    chk(rd == 0, "R9 lock untouched by user", rd, 0);
    read_all("R9 regs untouched by user");

    // R2: strobe sweep through register space
    for (int k = 0; k < 4; k++)
      for (int s = 1; s < 16; s++) begin
        d = {8'(k * 16 + s), 8'(s), 8'(k), 8'(s ^ 5)};
        acc(1, 3'd0, 3'(k), d, 4'(s), 0, e, rd);
        chk(!e, "R2 direct write ok", {31'd0, e}, 0);
        exp_reg[k] = merge(exp_reg[k], d, 4'(s));
        acc(0, 3'd0, 3'(k), 0, 4'hF, 0, e, rd);
        chk(!e && rd == exp_reg[k], "R2 direct read back", rd, exp_reg[k]);
      end

    // R8: reserved regions, bad offsets, misaligned
    for (int o = 0; o < 8; o++) begin
      acc(0, 3'd1, 3'(o), 0, 4'hF, 0, e, rd);
      chk(e && rd == 0, "R8 reserved region", {31'd0, e}, 1);
      for (int rg = 5; rg < 8; rg++) begin
        acc(1, 3'(rg), 3'(o), 32'hFFFF_FFFF, 4'hF, 0, e, rd);
        chk(e, "R8 upper reserved", {31'd0, e}, 1);
      end
    end
    for (int o = 4; o < 8; o++) begin
      acc(1, 3'd0, 3'(o), 32'h1, 4'hF, 0, e, rd);
      chk(e, "R8 direct out of range", {31'd0, e}, 1);
      acc(1, 3'd3, 3'(o), 32'hF, 4'hF, 0, e, rd);
      chk(e, "R8 lock out of range", {31'd0, e}, 1);
    end
    for (int o = 1; o < 8; o++) begin
      acc(1, 3'd4, 3'(o), 32'h3, 4'hF, 0, e, rd);
      chk(e, "R8 config out of range", {31'd0, e}, 1);
    end
    @(negedge clk);
    req_valid = 1; req_write = 1; req_user = 0; req_addr = 8'h02;
    req_wdata = 32'h0; req_strb = 4'hF;
    @(negedge clk);
    req_valid = 0;
    chk(rsp_err === 1'b1, "R8 misaligned", {31'd0, rsp_err}, 1);
    acc(0, 3'd4, 3'd0, 0, 4'hF, 0, e, rd);
    chk(rd == 0, "R8 config unchanged", rd, 0);
    read_all("R8 regs unchanged");

    // R3: mirror write on reg0 locks only bytes 2,3
    acc(1, 3'd2, 3'd0, 32'hA1B2C3D4, 4'hF, 0, e, rd);
    chk(!e, "R3 mirror write ok", {31'd0, e}, 0);
    exp_reg[0] = 32'hA1B2C3D4;
    acc(0, 3'd3, 3'd0, 0, 4'hF, 0, e, rd);
    chk(rd == 32'hC, "R3 masked locks", rd, 32'hC);
    acc(1, 3'd2, 3'd1, 32'h11223344, 4'b0101, 0, e, rd);
    exp_reg[1] = merge(exp_reg[1], 32'h11223344, 4'b0101);
    acc(0, 3'd3, 3'd1, 0, 4'hF, 0, e, rd);
    chk(rd == 32'h5, "R3 strobed locks", rd, 32'h5);

    // R4: mirror read
    acc(0, 3'd2, 3'd2, 0, 4'hF, 0, e, rd);
    chk(!e && rd == exp_reg[2], "R4 mirror read data", rd, exp_reg[2]);
    acc(0, 3'd3, 3'd2, 0, 4'hF, 0, e, rd);
    chk(rd == 0, "R4 mirror read no lock", rd, 0);

    // R5: collision blocks whole word
    acc(1, 3'd0, 3'd0, 32'h55555555, 4'b0101, 0, e, rd);
    chk(e, "R5 collide error", {31'd0, e}, 1);
    acc(1, 3'd0, 3'd0, 32'h000000EE, 4'b0001, 0, e, rd);
    chk(!e, "R5 unlocked byte ok", {31'd0, e}, 0);
    exp_reg[0] = merge(exp_reg[0], 32'hEE, 4'b0001);
    read_all("R5 whole word blocked");

    // R6: lock words, mask applied, clear
    acc(1, 3'd3, 3'd0, 32'h0, 4'hF, 0, e, rd);
    acc(1, 3'd3, 3'd1, 32'h0, 4'hF, 0, e, rd);
    acc(0, 3'd3, 3'd1, 0, 4'hF, 0, e, rd);
    chk(!e && rd == 0, "R6 clear", rd, 0);
    acc(1, 3'd3, 3'd0, 32'hF, 4'hF, 0, e, rd);
    acc(0, 3'd3, 3'd0, 0, 4'hF, 0, e, rd);
    chk(rd == 32'hC, "R6 mask on lock word", rd, 32'hC);
    acc(1, 3'd3, 3'd0, 32'h0, 4'hF, 0, e, rd);

    // R5/R6: every lock pattern against every strobe on reg1 and reg0
    for (int k = 0; k < 2; k++)
      for (int p = 0; p < 16; p++) begin
        acc(1, 3'd3, 3'(k), 32'(p), 4'hF, 0, e, rd);
        acc(0, 3'd3, 3'(k), 0, 4'hF, 0, e, rd);
        chk(rd == (32'(p) & 32'(PM[k*4 +: 4])), "R6 lock read back", rd,
            32'(p) & 32'(PM[k*4 +: 4]));
        for (int s = 1; s < 16; s++) begin
          d = {4{8'(p * 16 + s)}};
          exp_e = |(4'(s) & 4'(p) & PM[k*4 +: 4]);
          acc(1, 3'd0, 3'(k), d, 4'(s), 0, e, rd);
          chk(e == exp_e, "R5 sweep error", {31'd0, e}, {31'd0, exp_e});
          if (!exp_e) exp_reg[k] = merge(exp_reg[k], d, 4'(s));
        end
        acc(1, 3'd3, 3'(k), 32'h0, 4'hF, 0, e, rd);
      end
    read_all("R5 sweep contents");

    // R10: peripheral error passes through
    inj_en = 1; inj_idx = 2'd2;
    acc(0, 3'd0, 3'd2, 0, 4'hF, 0, e, rd);
    chk(e, "R10 read error pass", {31'd0, e}, 1);
    acc(1, 3'd2, 3'd2, 32'h12345678, 4'hF, 0, e, rd);
    chk(e, "R10 mirror write error pass", {31'd0, e}, 1);
    inj_en = 0;
    acc(0, 3'd3, 3'd2, 0, 4'hF, 0, e, rd);
    chk(rd == 0, "R10 no lock on rejected mirror", rd, 0);

    // R9: permission granted
    acc(1, 3'd4, 3'd0, 32'h2, 4'hF, 0, e, rd);
    acc(1, 3'd0, 3'd3, 32'hCAFEF00D, 4'hF, 1, e, rd);
    chk(!e, "R9 user write allowed", {31'd0, e}, 0);
    exp_reg[3] = 32'hCAFEF00D;

    // R7: hard lock
    acc(1, 3'd3, 3'd1, 32'h6, 4'hF, 0, e, rd);
    acc(1, 3'd4, 3'd0, 32'h3, 4'hF, 0, e, rd);
    acc(0, 3'd4, 3'd0, 0, 4'hF, 0, e, rd);
    chk(rd == 32'h3, "R7 config set", rd, 32'h3);
    acc(1, 3'd3, 3'd1, 32'h0, 4'hF, 0, e, rd);
    chk(e, "R7 lock write error", {31'd0, e}, 1);
    acc(0, 3'd3, 3'd1, 0, 4'hF, 0, e, rd);
    chk(rd == 32'h6, "R7 lock frozen", rd, 32'h6);
    acc(1, 3'd2, 3'd3, 32'h0, 4'hF, 0, e, rd);
    chk(e, "R7 mirror write error", {31'd0, e}, 1);
    acc(0, 3'd3, 3'd3, 0, 4'hF, 0, e, rd);
    chk(rd == 0, "R7 no mirror lock", rd, 0);
    acc(1, 3'd4, 3'd0, 32'h0, 4'hF, 0, e, rd);
    acc(0, 3'd4, 3'd0, 0, 4'hF, 0, e, rd);
    chk(rd == 32'h1, "R7 hard lock sticky", rd, 32'h1);
    acc(1, 3'd0, 3'd1, 32'h000000AA, 4'b0001, 0, e, rd);
    chk(!e, "R7 unlocked direct write ok", {31'd0, e}, 0);
    exp_reg[1] = merge(exp_reg[1], 32'hAA, 4'b0001);
    read_all("R7 final contents");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule